// File: doc/BRIEF.md
# Single-Wire Colour-Light Frame Transmitter

This block turns one lighting command into a timed waveform on a single data wire that feeds a chain of addressable colour lights. A host offers a bulb address, a brightness value and three colour nibbles with a valid/ready handshake. Once the command is taken, the block drives a high lead-in pulse. It then sends each payload bit as a low phase followed by a high phase, and the lengths of those two phases trade places between a zero and a one. The frame ends with a fixed low rest period.

All timing comes from one down-counter clocked by the system clock, so every phase length is an exact number of cycles. The defaults are 800 cycles for the short phases and the lead-in, and 1600 cycles for the long phases and the rest gap. At 80 MHz these are 10 µs and 20 µs. The block holds one command at a time. The host may offer the next command in the cycle after the completion pulse.

Top module: `lightFrameTx`

## Requirements
- R1: `inReady` is high exactly when no frame is in progress. A command is taken on a rising clock edge where `inValid` and `inReady` are both high, and `inReady` is low from the next cycle.
- R2: In the cycle after the command is taken, `lineOut` goes high and stays high for exactly `START_TICKS` cycles.
- R3: The 26 payload bits go out as the vector {address[5:0], level[7:0], blue[3:0], green[3:0], red[3:0]}, starting with bit 25 (address MSB) and ending with bit 0 (red LSB).
- R4: A payload bit of 0 is `lineOut` low for `SHORT_TICKS` cycles, then high for `LONG_TICKS` cycles.
- R5: A payload bit of 1 is `lineOut` low for `LONG_TICKS` cycles, then high for `SHORT_TICKS` cycles.
- R6: After the last high phase, `lineOut` stays low for `GAP_TICKS` cycles before the frame ends, with no cycles added between phases.
- R7: `frameDone` is high for one cycle only, in the last cycle of the rest gap. `inReady` is high in the following cycle.
- R8: `lineOut` is low after reset and whenever no frame is in progress. Changes on `inValid` or on the field inputs while a frame is in progress have no effect on the waveform.
- R9: A command offered in the cycle right after `frameDone` is taken, and it produces a correct frame with no extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Host offers a command |
| inReady | output | 1 | Block can take a command |
| inAddr | input | 6 | Bulb address |
| inLevel | input | 8 | Brightness |
| inBlue | input | 4 | Blue value |
| inGreen | input | 4 | Green value |
| inRed | input | 4 | Red value |
| lineOut | output | 1 | Serial data line |
| frameDone | output | 1 | One-cycle pulse marking the end of a frame |

## Verification
The bench builds the block with a lead-in of 3 cycles, short phases of 2, long phases of 5 and a gap of 4. With these values a full frame takes under 200 cycles. That makes it practical to compare the line level against an arithmetic model in every cycle of each frame. The frames cover a walking one and a walking zero across all 26 payload bit positions, the all-zero and all-ones payloads, and a set of pseudo-random payloads. Some frames follow each other back to back, and some have junk driven on the host inputs while the frame is in progress.

// File: rtl/lightFramePkg.sv
package lightFramePkg;
  localparam int ADDR_W  = 6;
  localparam int LEVEL_W = 8;
  localparam int COLOR_W = 4;
  localparam int FRAME_BITS = ADDR_W + LEVEL_W + 3 * COLOR_W;
  localparam int BITCNT_W = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT_LOW, ST_BIT_HIGH, ST_GAP
  } txState_t;

  // which duration the tick counter reloads with
  typedef enum logic [2:0] {
    DUR_START, DUR_LOW_CUR, DUR_LOW_NEXT, DUR_HIGH_CUR, DUR_GAP
  } durSel_t;

  typedef struct packed {
    logic    capture;
    logic    shift;
    logic    reload;
    durSel_t durSel;
  } txStrobes_t;
endpackage

// File: rtl/lightFrameData.sv
module lightFrameData
  import lightFramePkg::*;
#(
  parameter int START_TICKS = 800,
  parameter int SHORT_TICKS = 800,
  parameter int LONG_TICKS  = 1600,
  parameter int GAP_TICKS   = 1600
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           ctrl,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic [LEVEL_W-1:0]   inLevel,
  input  logic [COLOR_W-1:0]   inBlue,
  input  logic [COLOR_W-1:0]   inGreen,
  input  logic [COLOR_W-1:0]   inRed,
  output logic                 tickDone,
  output logic                 bitLast,
  output logic                 curBit
);
  localparam int MAX_A = (START_TICKS > SHORT_TICKS) ? START_TICKS : SHORT_TICKS;
  localparam int MAX_B = (LONG_TICKS > GAP_TICKS) ? LONG_TICKS : GAP_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TICK_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [BITCNT_W-1:0]   bitCnt;
  logic [TICK_W-1:0]     tickCnt;
  logic [TICK_W-1:0]     reloadVal;
  logic                  nextBit;

  assign curBit  = shiftReg[FRAME_BITS-1];
  assign nextBit = shiftReg[FRAME_BITS-2];
  assign bitLast = (bitCnt == '0);
  assign tickDone = (tickCnt == '0);

  always_comb begin
    unique case (ctrl.durSel)
      DUR_START:    reloadVal = TICK_W'(START_TICKS - 1);
      DUR_LOW_CUR:  reloadVal = curBit  ? TICK_W'(LONG_TICKS - 1) : TICK_W'(SHORT_TICKS - 1);
      DUR_LOW_NEXT: reloadVal = nextBit ? TICK_W'(LONG_TICKS - 1) : TICK_W'(SHORT_TICKS - 1);
      DUR_HIGH_CUR: reloadVal = curBit  ? TICK_W'(SHORT_TICKS - 1) : TICK_W'(LONG_TICKS - 1);
      DUR_GAP:      reloadVal = TICK_W'(GAP_TICKS - 1);
      default:      reloadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (ctrl.reload) begin
      tickCnt <= reloadVal;
    end else if (tickCnt != '0) begin
      tickCnt <= tickCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctrl.capture) begin
      shiftReg <= {inAddr, inLevel, inBlue, inGreen, inRed};
      bitCnt   <= BITCNT_W'(FRAME_BITS - 1);
    end else if (ctrl.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
      bitCnt   <= bitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/lightFrameCtrl.sv
module lightFrameCtrl
  import lightFramePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       tickDone,
  input  logic       bitLast,
  output txStrobes_t ctrl,
  output logic       inReady,
  output logic       lineOut,
  output logic       frameDone
);
  txState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctrl        = '0;
    ctrl.durSel = DUR_START;
    frameDone   = 1'b0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        ctrl.capture = 1'b1;
        ctrl.reload  = 1'b1;
        ctrl.durSel  = DUR_START;
        stateNext    = ST_START;
      end
      ST_START: if (tickDone) begin
        // shift register already holds the first bit
        ctrl.reload = 1'b1;
        ctrl.durSel = DUR_LOW_CUR;
        stateNext   = ST_BIT_LOW;
      end
      ST_BIT_LOW: if (tickDone) begin
        ctrl.reload = 1'b1;
        ctrl.durSel = DUR_HIGH_CUR;
        stateNext   = ST_BIT_HIGH;
      end
      ST_BIT_HIGH: if (tickDone) begin
        ctrl.reload = 1'b1;
        if (bitLast) begin
          ctrl.durSel = DUR_GAP;
          stateNext   = ST_GAP;
        end else begin
          ctrl.shift  = 1'b1;
          ctrl.durSel = DUR_LOW_NEXT;
          stateNext   = ST_BIT_LOW;
        end
      end
      ST_GAP: if (tickDone) begin
        frameDone = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady = (state == ST_IDLE);
  assign lineOut = (state == ST_START) || (state == ST_BIT_HIGH);
endmodule

// File: rtl/lightFrameTx.sv
module lightFrameTx
  import lightFramePkg::*;
#(
  parameter int START_TICKS = 800,
  parameter int SHORT_TICKS = 800,
  parameter int LONG_TICKS  = 1600,
  parameter int GAP_TICKS   = 1600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [5:0]  inAddr,
  input  logic [7:0]  inLevel,
  input  logic [3:0]  inBlue,
  input  logic [3:0]  inGreen,
  input  logic [3:0]  inRed,
  output logic        lineOut,
  output logic        frameDone
);
  txStrobes_t ctrl;
  logic tickDone, bitLast, curBit;

  lightFrameCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tickDone(tickDone),
    .bitLast(bitLast), .ctrl(ctrl), .inReady(inReady), .lineOut(lineOut),
    .frameDone(frameDone)
  );

  lightFrameData #(
    .START_TICKS(START_TICKS), .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS(LONG_TICKS), .GAP_TICKS(GAP_TICKS)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inAddr(inAddr), .inLevel(inLevel),
    .inBlue(inBlue), .inGreen(inGreen), .inRed(inRed),
    .tickDone(tickDone), .bitLast(bitLast), .curBit(curBit)
  );
endmodule

// File: rtl/lightFrameChk.sv
module lightFrameChk #(
  parameter int START_TICKS = 800,
  parameter int SHORT_TICKS = 800,
  parameter int LONG_TICKS  = 1600,
  parameter int GAP_TICKS   = 1600
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic lineOut,
  input logic frameDone
);
  logic [31:0] highLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        highLen <= '0;
    else if (lineOut) highLen <= highLen + 1;
    else              highLen <= '0;
  end

  // R1 / R2: acceptance starts the lead-in and drops ready
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (lineOut && !inReady));

  // R8: line rests low while idle
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !lineOut);

  // R6: rest gap is low at its end
  assert_gap_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!lineOut && !inReady));

  // R7: completion is a single pulse followed by ready
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (!frameDone && inReady));

  // R4 / R5: every high run is one of the legal lengths
  assert_high_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!lineOut && highLen != 0) |->
      (highLen == START_TICKS || highLen == SHORT_TICKS || highLen == LONG_TICKS));
endmodule

bind lightFrameTx lightFrameChk #(
  .START_TICKS(START_TICKS), .SHORT_TICKS(SHORT_TICKS),
  .LONG_TICKS(LONG_TICKS), .GAP_TICKS(GAP_TICKS)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .lineOut(lineOut), .frameDone(frameDone)
);

// File: tb/sim_lightFrameTx.sv
module sim_lightFrameTx;
  localparam int CLK_PERIOD = 10;
  localparam int T_START = 3;
  localparam int T_SHORT = 2;
  localparam int T_LONG  = 5;
  localparam int T_GAP   = 4;
  localparam int NBITS   = 26;
  localparam int FRAME_LEN = T_START + NBITS * (T_SHORT + T_LONG) + T_GAP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [5:0] inAddr = '0;
  logic [7:0] inLevel = '0;
  logic [3:0] inBlue = '0, inGreen = '0, inRed = '0;
  logic lineOut, frameDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  lightFrameTx #(
    .START_TICKS(T_START), .SHORT_TICKS(T_SHORT),
    .LONG_TICKS(T_LONG), .GAP_TICKS(T_GAP)
  ) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inLevel(inLevel), .inBlue(inBlue), .inGreen(inGreen),
    .inRed(inRed), .lineOut(lineOut), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected line level at cycle idx after acceptance (R2..R6)
  function automatic logic expLevel(input int idx, input logic [25:0] v);
    int k = idx;
    if (k < T_START) return 1'b1;
    k -= T_START;
    for (int b = NBITS - 1; b >= 0; b--) begin
      int lo = v[b] ? T_LONG : T_SHORT;
      int hi = v[b] ? T_SHORT : T_LONG;
      if (k < lo) return 1'b0;
      k -= lo;
      if (k < hi) return 1'b1;
      k -= hi;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] stepLfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // called at a negedge with the block idle; returns at the negedge after the frame
  task automatic runFrame(input logic [25:0] v, input bit junk);
    int waveErr = 0;
    int firstBad = -1;
    int badAct = 0;
    int badExp = 0;
    check(inReady === 1'b1, "R1 ready before offer", int'(inReady), 1);
    {inAddr, inLevel, inBlue, inGreen, inRed} = v;
    inValid = 1'b1;
    @(negedge clk);
    for (int idx = 0; idx < FRAME_LEN; idx++) begin
      logic e = expLevel(idx, v);
      if (lineOut !== e) begin
        waveErr++;
        if (firstBad < 0) begin firstBad = idx; badAct = int'(lineOut); badExp = int'(e); end
      end
      if (inReady !== 1'b0) begin
        waveErr++;
        if (firstBad < 0) begin firstBad = idx; badAct = int'(inReady); badExp = 0; end
      end
      if (frameDone !== (idx == FRAME_LEN - 1)) begin
        waveErr++;
        if (firstBad < 0) begin firstBad = idx; badAct = int'(frameDone); badExp = int'(idx == FRAME_LEN - 1); end
      end
      // R8: inputs during the frame must not matter
      if (junk) begin
        lfsr = stepLfsr(lfsr);
        {inAddr, inLevel, inBlue, inGreen, inRed} = lfsr[25:0];
        inValid = (idx != FRAME_LEN - 1) ? lfsr[31] : 1'b0;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    check(waveErr == 0, $sformatf("R3/R4/R5/R6/R7 waveform cycle %0d", firstBad), badAct, badExp);
    check(inReady === 1'b1 && lineOut === 1'b0 && frameDone === 1'b0,
          "R7 ready after done", int'({inReady, lineOut, frameDone}), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lineOut === 1'b0 && inReady === 1'b1 && frameDone === 1'b0,
          "R8 reset state", int'({inReady, lineOut, frameDone}), 4);
    rstN = 1'b1;
    @(negedge clk);
    check(lineOut === 1'b0 && inReady === 1'b1, "R8 idle after reset",
          int'({inReady, lineOut}), 2);
    // R3: walking one across every payload bit
    for (int b = 0; b < NBITS; b++) runFrame(26'(1) << b, 1'b0);
    // walking zero, back to back (R9)
    for (int b = 0; b < NBITS; b++) runFrame(~(26'(1) << b), b[0]);
    runFrame('0, 1'b1);
    runFrame('1, 1'b1);
    // idle gap then a frame (R1, R8)
    repeat (5) begin
      @(negedge clk);
      check(lineOut === 1'b0 && inReady === 1'b1, "R8 idle line", int'({inReady, lineOut}), 2);
    end
    for (int n = 0; n < 12; n++) begin
      lfsr = stepLfsr(lfsr);
      runFrame(lfsr[25:0], 1'b1);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule